// File: doc/BRIEF.md
# Auto-Masking Hardware Interrupt Distributor

This block gathers a set of level-sensitive hardware interrupt lines and delivers each of them to any subset of a small group of processor targets. Every interrupt owns three pieces of control state: a target bitfield that names the destinations it reaches, a mask bit, and a software-generate bit. The software-generate bit is ORed with the hardware line. The mask and software-generate bits are kept in paired set/clear registers, so software never needs a read-modify-write sequence.

A processor learns what to service by reading the reason register. The requester-ID input selects whose view is used. The read returns the lowest-numbered interrupt that is pending for that requester. In the same cycle it sets that interrupt's mask bit, so the output drops on the next cycle. Once the source has been serviced, software clears the mask bit. If the line is still high at that point, the interrupt is delivered again.

The register port uses word addresses and returns read data one cycle after the request. A two-state machine tracks that response. In `ST_IDLE`, the transition `read_accept` (a request with write-enable low) moves it to `ST_RDATA`. In `ST_RDATA`, `read_again` keeps it in `ST_RDATA`, and `read_done` (no read request) returns it to `ST_IDLE`. Writes never leave `ST_IDLE`.

Top module: `irq_router`

## Requirements
- R1: After reset every mask bit is 1, every target and software-generate bit is 0, every interrupt output is low, and the reason register reads 0 for every requester.
- R2: Each mask and software-generate word is a set/clear pair. Reading either member returns the current bits. A 1 written to the set member sets the matching bit, and a 1 written to the clear member clears it. Bits written as 0 stay unchanged.
- R3: Word addresses: reason 0x0801; target of interrupt n at 0x0C00+n; software-generate set 0x1000+w and clear 0x1020+w; mask set 0x1040+w and clear 0x1060+w; line monitor 0x1080+w. Word w holds interrupts 32w..32w+31, with interrupt 32w+b in bit b. Bits of interrupts at or above NUM_IRQ, words beyond the last one, targets at or above NUM_IRQ and all unmapped addresses read 0.
- R4: Bit d of a target register selects destination d, for up to 11 destinations. Bits at or above NUM_TGT read 0. An interrupt is delivered to every destination whose bit is set.
- R5: The software-generate bit is ORed with the hardware line before masking. The monitor region shows only the hardware lines.
- R6: Output d is high exactly when some interrupt has a high combined line, a clear mask bit and target bit d set.
- R7: The reason value is {14'b0, 2'b01, number[15:0]}, where type 1 means a hardware interrupt. The number is the lowest-numbered interrupt pending for the requester that bus_rid names. The value is 0 when nothing is pending or when bus_rid is NUM_TGT or more.
- R8: A reason read that returns a nonzero value sets that interrupt's mask bit, so its output deasserts on the next cycle. A reason read that returns 0 changes nothing.
- R9: Clearing the mask bit while the combined line is still high makes the interrupt pending again, and the output reasserts.
- R10: bus_rdata and bus_rvalid are valid in the cycle after a read request, and bus_rvalid is low after a cycle with no read. Writes to the reason register or to the monitor region change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Register access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rid | input | 4 | Requester ID; selects the destination view for reason reads |
| bus_rdata | output | 32 | Read data, one cycle after the read request |
| bus_rvalid | output | 1 | High in the cycle when bus_rdata holds a read result |
| hw_irq | input | NUM_IRQ | Level-sensitive hardware interrupt lines |
| irq_out | output | NUM_TGT | One interrupt request per destination |

## Verification
The bench builds the block with NUM_IRQ=40 and NUM_TGT=3. With 40 interrupts, the second bitfield word is only partly populated, so the zero-fill above the last interrupt can be observed at the port. Three destinations are enough to show a reason read for a different requester returning nothing. Both sizes are small enough to sweep every interrupt against every destination through the full raise, report, auto-mask and release sequence. The priority cases place pending interrupts in both words, and the re-arm cases cover a line that stays high and a software-generated source.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int ADDR_W       = 14;
    localparam int DATA_W       = 32;
    localparam int RID_W        = 4;
    localparam int MAX_TGT      = 11;
    localparam int REGION_WORDS = 32;
    // Bitfield vectors are zero-padded to a full region plus one spare word.
    localparam int PAD_W        = REGION_WORDS * DATA_W + DATA_W;

    localparam logic [ADDR_W-1:0] A_REASON = 14'h0801;
    localparam logic [1:0]        KIND_HW  = 2'b01;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_RDATA
    } port_state_t;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_REASON,
        RG_TGT,
        RG_SWG_SET,
        RG_SWG_CLR,
        RG_MSK_SET,
        RG_MSK_CLR,
        RG_MON
    } region_t;

    function automatic region_t decode_region(input logic [ADDR_W-1:0] a);
        region_t r;
        r = RG_NONE;
        if (a == A_REASON) begin
            r = RG_REASON;
        end else if (a[13:10] == 4'b0011) begin
            r = RG_TGT;
        end else if (a[13:8] == 6'b010000) begin
            case (a[7:5])
                3'd0:    r = RG_SWG_SET;
                3'd1:    r = RG_SWG_CLR;
                3'd2:    r = RG_MSK_SET;
                3'd3:    r = RG_MSK_CLR;
                3'd4:    r = RG_MON;
                default: r = RG_NONE;
            endcase
        end
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] reason_word(input logic hit, input logic [15:0] num);
        return hit ? {14'd0, KIND_HW, num} : '0;
    endfunction

endpackage

// File: rtl/irq_state_bank.sv
module irq_state_bank
    import irq_router_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_TGT = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  region_t                          wr_region,
    input  logic [4:0]                       wr_word,
    input  logic [9:0]                       wr_irq,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic                             ack_en,
    input  logic [15:0]                      ack_idx,
    output logic [NUM_IRQ-1:0]               mask_q,
    output logic [NUM_IRQ-1:0]               swg_q,
    output logic [NUM_IRQ-1:0][NUM_TGT-1:0]  tgt_q
);

    localparam logic [PAD_W-1:0] VALID_PAD = PAD_W'({NUM_IRQ{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
            swg_q  <= '0;
            tgt_q  <= '0;
        end else begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (wr_en && wr_word == 5'(i / 32) && wr_data[i % 32]) begin
                    case (wr_region)
                        RG_SWG_SET: swg_q[i]  <= 1'b1;
                        RG_SWG_CLR: swg_q[i]  <= 1'b0;
                        RG_MSK_SET: mask_q[i] <= 1'b1;
                        RG_MSK_CLR: mask_q[i] <= 1'b0;
                        default:    ;
                    endcase
                end
                if (wr_en && wr_region == RG_TGT && wr_irq == 10'(i)) begin
                    tgt_q[i] <= wr_data[NUM_TGT-1:0];
                end
                if (ack_en && ack_idx == 16'(i)) begin
                    mask_q[i] <= 1'b1;
                end
            end
        end
    end

    logic [PAD_W-1:0] mask_pad;
    logic [PAD_W-1:0] swg_pad;
    assign mask_pad = PAD_W'(mask_q);
    assign swg_pad  = PAD_W'(swg_q);

    // R8
    ack_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_en |=> mask_pad[{1'b0, $past(ack_idx[9:0])}]);

    // R2
    swg_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_region == RG_SWG_CLR) |=>
        ((swg_pad[{1'b0, $past(wr_word), 5'd0} +: 32] & $past(wr_data)) == 32'd0));

    // R2
    msk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_region == RG_MSK_SET) |=>
        ((mask_pad[{1'b0, $past(wr_word), 5'd0} +: 32] & $past(wr_data)) ==
         (VALID_PAD[{1'b0, $past(wr_word), 5'd0} +: 32] & $past(wr_data))));

endmodule

// File: rtl/irq_pending_sel.sv
module irq_pending_sel
    import irq_router_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_TGT = 4
) (
    input  logic [NUM_IRQ-1:0]               hw_irq,
    input  logic [NUM_IRQ-1:0]               swg_q,
    input  logic [NUM_IRQ-1:0]               mask_q,
    input  logic [NUM_IRQ-1:0][NUM_TGT-1:0]  tgt_q,
    input  logic [RID_W-1:0]                 rid,
    output logic [NUM_TGT-1:0]               irq_out,
    output logic                             rsn_hit,
    output logic [15:0]                      rsn_idx
);

    logic [NUM_IRQ-1:0] active;
    assign active = (hw_irq | swg_q) & ~mask_q;

    for (genvar t = 0; t < NUM_TGT; t++) begin : g_dest
        logic [NUM_IRQ-1:0] col;
        always_comb begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                col[i] = tgt_q[i][t];
            end
        end
        assign irq_out[t] = |(active & col);
    end

    logic [NUM_IRQ-1:0] rid_col;
    always_comb begin
        rid_col = '0;
        for (int t = 0; t < NUM_TGT; t++) begin
            if (rid == RID_W'(t)) begin
                for (int i = 0; i < NUM_IRQ; i++) begin
                    rid_col[i] = tgt_q[i][t];
                end
            end
        end
    end

    // Scan downward so the lowest pending index is the last to win.
    always_comb begin
        rsn_hit = 1'b0;
        rsn_idx = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (active[i] && rid_col[i]) begin
                rsn_hit = 1'b1;
                rsn_idx = 16'(i);
            end
        end
    end

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_router_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_TGT = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_req,
    input  logic                             bus_we,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [DATA_W-1:0]                bus_wdata,
    output logic [DATA_W-1:0]                bus_rdata,
    output logic                             bus_rvalid,
    input  logic [NUM_IRQ-1:0]               hw_irq,
    input  logic [NUM_IRQ-1:0]               swg_q,
    input  logic [NUM_IRQ-1:0]               mask_q,
    input  logic [NUM_IRQ-1:0][NUM_TGT-1:0]  tgt_q,
    input  logic                             rsn_hit,
    input  logic [15:0]                      rsn_idx,
    output logic                             wr_en,
    output region_t                          wr_region,
    output logic [4:0]                       wr_word,
    output logic [9:0]                       wr_irq,
    output logic [DATA_W-1:0]                wr_data,
    output logic                             ack_en,
    output logic [15:0]                      ack_idx
);

    port_state_t state_q, state_d;
    region_t     region;
    logic        rd_req;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rdata_q;
    logic [PAD_W-1:0]  mask_pad, swg_pad, mon_pad;
    logic [10:0]       word_base;

    assign region    = decode_region(bus_addr);
    assign rd_req    = bus_req && !bus_we;
    assign wr_en     = bus_req && bus_we;
    assign wr_region = region;
    assign wr_word   = bus_addr[4:0];
    assign wr_irq    = bus_addr[9:0];
    assign wr_data   = bus_wdata;
    assign ack_en    = rd_req && region == RG_REASON && rsn_hit;
    assign ack_idx   = rsn_idx;

    assign mask_pad  = PAD_W'(mask_q);
    assign swg_pad   = PAD_W'(swg_q);
    assign mon_pad   = PAD_W'(hw_irq);
    assign word_base = {1'b0, bus_addr[4:0], 5'd0};

    always_comb begin
        rd_word = '0;
        case (region)
            RG_REASON: rd_word = reason_word(rsn_hit, rsn_idx);
            RG_TGT: begin
                for (int i = 0; i < NUM_IRQ; i++) begin
                    if (bus_addr[9:0] == 10'(i)) rd_word = DATA_W'(tgt_q[i]);
                end
            end
            RG_SWG_SET, RG_SWG_CLR: rd_word = swg_pad[word_base +: DATA_W];
            RG_MSK_SET, RG_MSK_CLR: rd_word = mask_pad[word_base +: DATA_W];
            RG_MON:                 rd_word = mon_pad[word_base +: DATA_W];
            default:                rd_word = '0;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: read_accept / read_again / read_done.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = rd_req ? ST_RDATA : ST_IDLE;
            ST_RDATA: state_d = rd_req ? ST_RDATA : ST_IDLE;
        endcase
    end

    // Outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_req) rdata_q <= rd_word;
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = (state_q == ST_RDATA);

    // R10
    rsp_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);

    // R10
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !bus_rvalid);

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_TGT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [13:0]         bus_addr,
    input  logic [31:0]         bus_wdata,
    input  logic [3:0]          bus_rid,
    output logic [31:0]         bus_rdata,
    output logic                bus_rvalid,
    input  logic [NUM_IRQ-1:0]  hw_irq,
    output logic [NUM_TGT-1:0]  irq_out
);

    logic [NUM_IRQ-1:0]              mask_q, swg_q;
    logic [NUM_IRQ-1:0][NUM_TGT-1:0] tgt_q;
    logic        wr_en, ack_en, rsn_hit;
    region_t     wr_region;
    logic [4:0]  wr_word;
    logic [9:0]  wr_irq;
    logic [31:0] wr_data;
    logic [15:0] ack_idx, rsn_idx;

    irq_state_bank #(.NUM_IRQ(NUM_IRQ), .NUM_TGT(NUM_TGT)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_region (wr_region),
        .wr_word   (wr_word),
        .wr_irq    (wr_irq),
        .wr_data   (wr_data),
        .ack_en    (ack_en),
        .ack_idx   (ack_idx),
        .mask_q    (mask_q),
        .swg_q     (swg_q),
        .tgt_q     (tgt_q)
    );

    irq_pending_sel #(.NUM_IRQ(NUM_IRQ), .NUM_TGT(NUM_TGT)) u_sel (
        .hw_irq  (hw_irq),
        .swg_q   (swg_q),
        .mask_q  (mask_q),
        .tgt_q   (tgt_q),
        .rid     (bus_rid),
        .irq_out (irq_out),
        .rsn_hit (rsn_hit),
        .rsn_idx (rsn_idx)
    );

    irq_reg_port #(.NUM_IRQ(NUM_IRQ), .NUM_TGT(NUM_TGT)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .hw_irq     (hw_irq),
        .swg_q      (swg_q),
        .mask_q     (mask_q),
        .tgt_q      (tgt_q),
        .rsn_hit    (rsn_hit),
        .rsn_idx    (rsn_idx),
        .wr_en      (wr_en),
        .wr_region  (wr_region),
        .wr_word    (wr_word),
        .wr_irq     (wr_irq),
        .wr_data    (wr_data),
        .ack_en     (ack_en),
        .ack_idx    (ack_idx)
    );

    // R6
    all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> (irq_out == '0));

    // R7
    reported_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsn_hit |-> (irq_out != '0));

endmodule

// File: tb/tb_irq_router.sv
module tb_irq_router;

    localparam int NI = 40;
    localparam int NT = 3;
    localparam logic [13:0] REASON  = 14'h0801;
    localparam logic [13:0] TGT     = 14'h0C00;
    localparam logic [13:0] SWG_SET = 14'h1000;
    localparam logic [13:0] SWG_CLR = 14'h1020;
    localparam logic [13:0] MSK_SET = 14'h1040;
    localparam logic [13:0] MSK_CLR = 14'h1060;
    localparam logic [13:0] MON     = 14'h1080;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_req = 1'b0, bus_we = 1'b0;
    logic [13:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_rid = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [NI-1:0] hw_irq = '0;
    logic [NT-1:0] irq_out;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    irq_router #(.NUM_IRQ(NI), .NUM_TGT(NT)) dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rid(bus_rid),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .hw_irq(hw_irq), .irq_out(irq_out)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [13:0] a, input logic [3:0] rid, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_rid = rid;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
        chk("R10 rvalid after read", 32'(bus_rvalid), 32'd1);
    endtask

    // Expected word of a fully set bitfield: ones only below NI.
    function automatic logic [31:0] full_word(input int w);
        logic [31:0] v = '0;
        for (int b = 0; b < 32; b++) if (w * 32 + b < NI) v[b] = 1'b1;
        return v;
    endfunction

    function automatic logic [31:0] rsn(input int n);
        return 32'h0001_0000 | 32'(n);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1 chk("R1 outputs low", 32'(irq_out), 32'd0);
        chk("R1 rvalid low", 32'(bus_rvalid), 32'd0);
        for (int w = 0; w < 2; w++) begin
            rd(MSK_SET + 14'(w), 4'd0, d); chk("R1 mask set after reset", d, full_word(w));
            rd(SWG_SET + 14'(w), 4'd0, d); chk("R1 swgen clear after reset", d, 32'd0);
        end
        for (int i = 0; i < NI; i++) begin
            rd(TGT + 14'(i), 4'd0, d); chk("R1 target clear after reset", d, 32'd0);
        end
        for (int t = 0; t < NT; t++) begin
            rd(REASON, 4'(t), d); chk("R1 reason zero after reset", d, 32'd0);
        end
        @(negedge clk); chk("R10 rvalid drops", 32'(bus_rvalid), 32'd0);

        // R3 unmapped and out-of-range words
        rd(MSK_SET + 14'd2, 4'd0, d); chk("R3 word past end", d, 32'd0);
        rd(TGT + 14'(NI), 4'd0, d);   chk("R3 target past end", d, 32'd0);
        rd(14'h0000, 4'd0, d);         chk("R3 unmapped address", d, 32'd0);

        // R2 set/clear pair
        wr(MSK_CLR, 32'h0000_000F);
        rd(MSK_SET, 4'd0, d); chk("R2 clear via clr member", d, 32'hFFFF_FFF0);
        rd(MSK_CLR, 4'd0, d); chk("R2 read of clr member", d, 32'hFFFF_FFF0);
        wr(MSK_SET, 32'h0000_0003);
        rd(MSK_SET, 4'd0, d); chk("R2 set via set member", d, 32'hFFFF_FFF3);
        wr(MSK_CLR, 32'h0000_0000);
        rd(MSK_SET, 4'd0, d); chk("R2 zero write no change", d, 32'hFFFF_FFF3);
        wr(MSK_SET, 32'h0000_000C);
        rd(MSK_SET, 4'd0, d); chk("R2 restore", d, 32'hFFFF_FFFF);

        // R4 target width
        wr(TGT + 14'd7, 32'hFFFF_FFFF);
        rd(TGT + 14'd7, 4'd0, d); chk("R4 target upper bits zero", d, 32'h7);
        wr(TGT + 14'd7, 32'd0);

        // Main sweep: every interrupt against every destination (R6 R7 R8)
        for (int i = 0; i < NI; i++) begin
            for (int t = 0; t < NT; t++) begin
                wr(TGT + 14'(i), 32'(1 << t));
                wr(MSK_CLR + 14'(i / 32), 32'(1) << (i % 32));
                #1 chk("R6 line low no output", 32'(irq_out), 32'd0);
                hw_irq[i] = 1'b1;
                #1 chk("R6 routed output", 32'(irq_out), 32'(1 << t));
                rd(REASON, 4'((t + 1) % NT), d); chk("R7 other view empty", d, 32'd0);
                chk("R8 empty read no side effect", 32'(irq_out), 32'(1 << t));
                rd(REASON, 4'(t), d); chk("R7 reason value", d, rsn(i));
                chk("R8 output drops after read", 32'(irq_out), 32'd0);
                rd(MSK_SET + 14'(i / 32), 4'd0, d);
                chk("R8 mask bit set by read", d, full_word(i / 32));
                hw_irq[i] = 1'b0;
                wr(TGT + 14'(i), 32'd0);
            end
        end

        // R7 lowest first, across both words; out-of-range requester
        wr(TGT + 14'd3, 32'd1); wr(TGT + 14'd17, 32'd1); wr(TGT + 14'd33, 32'd1);
        wr(MSK_CLR, (32'd1 << 3) | (32'd1 << 17));
        wr(MSK_CLR + 14'd1, 32'd1 << 1);
        @(negedge clk); hw_irq[3] = 1'b1; hw_irq[17] = 1'b1; hw_irq[33] = 1'b1;
        rd(REASON, 4'd5, d); chk("R7 requester out of range", d, 32'd0);
        rd(REASON, 4'd0, d); chk("R7 lowest first", d, rsn(3));
        rd(REASON, 4'd0, d); chk("R7 next lowest", d, rsn(17));
        rd(REASON, 4'd0, d); chk("R7 second word", d, rsn(33));
        rd(REASON, 4'd0, d); chk("R7 none left", d, 32'd0);
        chk("R8 all acknowledged", 32'(irq_out), 32'd0);
        hw_irq = '0;
        wr(TGT + 14'd3, 32'd0); wr(TGT + 14'd17, 32'd0); wr(TGT + 14'd33, 32'd0);

        // R4 multi-destination, R9 re-arm with line still high
        wr(TGT + 14'd5, 32'd3);
        wr(MSK_CLR, 32'd1 << 5);
        hw_irq[5] = 1'b1;
        #1 chk("R4 two destinations", 32'(irq_out), 32'd3);
        rd(REASON, 4'd1, d); chk("R7 view of destination 1", d, rsn(5));
        chk("R8 both destinations drop", 32'(irq_out), 32'd0);
        wr(MSK_CLR, 32'd1 << 5);
        #1 chk("R9 reassert after unmask", 32'(irq_out), 32'd3);
        hw_irq[5] = 1'b0;
        #1 chk("R6 line low clears output", 32'(irq_out), 32'd0);
        wr(MSK_SET, 32'd1 << 5);
        wr(TGT + 14'd5, 32'd0);

        // R5 software generate and monitor
        wr(TGT + 14'd20, 32'd4);
        wr(MSK_CLR, 32'd1 << 20);
        wr(SWG_SET, 32'd1 << 20);
        #1 chk("R5 swgen drives output", 32'(irq_out), 32'd4);
        rd(MON, 4'd0, d); chk("R5 monitor ignores swgen", d, 32'd0);
        rd(SWG_CLR, 4'd0, d); chk("R2 swgen via clr member", d, 32'd1 << 20);
        rd(REASON, 4'd2, d); chk("R5 swgen reported", d, rsn(20));
        chk("R8 swgen masked by read", 32'(irq_out), 32'd0);
        wr(SWG_CLR, 32'd1 << 20);
        wr(MSK_CLR, 32'd1 << 20);
        #1 chk("R5 swgen cleared", 32'(irq_out), 32'd0);
        hw_irq[35] = 1'b1;
        rd(MON + 14'd1, 4'd0, d); chk("R5 monitor shows line", d, 32'd1 << 3);
        hw_irq[35] = 1'b0;
        wr(MSK_SET, 32'd1 << 20);
        wr(TGT + 14'd20, 32'd0);

        // R10 writes to reason and monitor are ignored
        wr(REASON, 32'hFFFF_FFFF);
        wr(MON, 32'hFFFF_FFFF);
        rd(MSK_SET, 4'd0, d); chk("R10 mask untouched", d, 32'hFFFF_FFFF);
        rd(SWG_SET, 4'd0, d); chk("R10 swgen untouched", d, 32'd0);
        rd(MON, 4'd0, d);     chk("R10 monitor untouched", d, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule